// File: doc/BRIEF.md
# Word-Mapped Serial Port Register Front End

This block is the register file and control front end of a PC-style serial port with 16-entry transmit and receive queues. Software sees it over a 32-bit bus. Every register has its own word-aligned slot, so no offset is shared and there is no bank-select bit. A separate enable register gates the port. One divisor register, counted against the bus clock, sets the rate of a baud tick.

The bit-level shifters lie outside the block. The transmit side hands bytes out through a valid/take handshake. The receive side accepts bytes through a push strobe. The block presents line status, a prioritised interrupt cause, modem status with change flags, and a single interrupt output.

Top module: `flat_uart_regs`

## Requirements
- R1: After reset, every stored register reads 0, interrupt cause reads 0x01, line status reads 0x60, `txValid` and `irq` are low.
- R2: Each register has its own word slot. Byte address bits [8:2] select the slot: 0 receive data, 1 transmit data, 2 interrupt enable, 3 interrupt cause, 4 queue control, 5 line control, 6 modem control, 7 line status, 8 modem status, 10 divisor, 64 (0x100) enable in bit 0. Data sits in the low bits, upper bits read 0. Unmapped slots, and the transmit data and queue control slots, read 0.
- R3: A write whose byte enables are not 4'hF changes nothing.
- R4: While enable bit 0 is clear, transmit writes, receive pushes, receive pops and transmit takes are ignored, and `baudTick` stays low.
- R5: A write to transmit data appends to a 16-entry queue. `txValid`/`txByte` present the oldest entry, and `txTake` removes it. A write to a full queue is dropped.
- R6: `rxPush` appends `rxByte`, and a read of receive data returns and removes the oldest entry. Line status bit 0 shows data ready. A push into a full queue is dropped and sets line status bit 1 (overrun), which a line status read clears. Bits 5 and 6 are set while the transmit queue is empty.
- R7: Line control bit 7 and modem control bit 5 read 0 whatever is written. Modem control bits [4:0] drive `modemOut`.
- R8: With a nonzero divisor N and enable set, `baudTick` pulses once every N clocks, and N=1 holds it high. A divisor of 0 stops it.
- R9: Interrupt cause bit 0 is 1 when nothing is pending. Bits [3:1] name the highest enabled source: 011 overrun (enable bit 2), 010 receive level (enable bit 0), 001 transmit empty (enable bit 1), 000 modem change (enable bit 3). Bits [7:6] are 11 while queue control bit 0 is set.
- R10: Transmit-empty becomes pending when the transmit queue turns empty, or when enable bit 1 is set while it is empty. A cause read that reports it, or a transmit write, clears it.
- R11: Queue control bit 1 flushes the receive queue and bit 2 flushes the transmit queue. Bits [7:6] pick the receive level 1, 4, 8 or 14 when bit 0 is set, and the level is 1 otherwise.
- R12: Modem status bits [7:4] show `modemIn` registered once. Bits [3:0] latch any change of the matching input, and a modem status read clears them.
- R13: `irq` is high exactly when interrupt cause bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Access in this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 9 | Byte address |
| busBe | input | 4 | Byte enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| txValid | output | 1 | Transmit queue holds a byte |
| txByte | output | 8 | Oldest transmit byte |
| txTake | input | 1 | Shifter takes the byte |
| rxPush | input | 1 | Shifter delivers a byte |
| rxByte | input | 8 | Delivered byte |
| modemIn | input | 4 | Modem input lines |
| modemOut | output | 5 | Modem control bits |
| lineCfg | output | 7 | Line control bits |
| baudTick | output | 1 | Baud rate pulse |
| irq | output | 1 | Interrupt request |

## Verification
Register slots get distinct values, including all-ones and upper-bit garbage, so that aliasing between slots and leakage into high bits show up. The queues are driven to exactly full and one beyond, which separates an off-by-one depth from a correct drop and overrun. The interrupt sources are raised in stacked combinations and removed one at a time, so each step of the priority order is seen on its own. The baud tick runs with divisors 5, 1 and 0, which separates a correct period from a stuck or free-running counter.

// File: rtl/flat_uart_pkg.sv
package flat_uart_pkg;
  localparam int IDX_RXD = 0;
  localparam int IDX_TXD = 1;
  localparam int IDX_IEN = 2;
  localparam int IDX_ICS = 3;
  localparam int IDX_QCT = 4;
  localparam int IDX_LCT = 5;
  localparam int IDX_MCT = 6;
  localparam int IDX_LST = 7;
  localparam int IDX_MST = 8;
  localparam int IDX_DIV = 10;
  localparam int IDX_ENA = 64;

  typedef struct packed {
    logic       txPush;
    logic [7:0] txData;
    logic       rxPop;
    logic       txClear;
    logic       rxClear;
    logic       lsrRead;
    logic       msrRead;
    logic       causeRead;
    logic       divWrite;
    logic       threArm;
  } uartStrobes_t;

  typedef struct packed {
    logic [7:0] rxHead;
    logic [7:0] lineStat;
    logic [7:0] intCause;
    logic [7:0] modemStat;
  } uartStatus_t;
endpackage

// File: rtl/flat_uart_fifo.sv
module flat_uart_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign dout   = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !clear) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clear) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/flat_uart_ctrl.sv
module flat_uart_ctrl
  import flat_uart_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  uartStatus_t       status,
  output uartStrobes_t      strobes,
  output logic              enable,
  output logic [3:0]        intEnable,
  output logic [6:0]        lineCfg,
  output logic [4:0]        modemCfg,
  output logic              queueMode,
  output logic [1:0]        rxLevelSel,
  output logic [DIV_W-1:0]  divisor
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] slot;
  logic wrOk, rdOk;

  assign slot = busAddr[ADDR_W-1:2];
  assign wrOk = busSel && busWrite && (busBe == 4'hF);
  assign rdOk = busSel && !busWrite;

  function automatic logic hit(input logic [IW-1:0] s, input int idx);
    return s == IW'(idx);
  endfunction

  always_comb begin
    strobes           = '0;
    strobes.txPush    = wrOk && hit(slot, IDX_TXD);
    strobes.txData    = busWdata[7:0];
    strobes.txClear   = wrOk && hit(slot, IDX_QCT) && busWdata[2];
    strobes.rxClear   = wrOk && hit(slot, IDX_QCT) && busWdata[1];
    strobes.divWrite  = wrOk && hit(slot, IDX_DIV);
    strobes.threArm   = wrOk && hit(slot, IDX_IEN) && busWdata[1] && !intEnable[1];
    strobes.rxPop     = rdOk && hit(slot, IDX_RXD);
    strobes.lsrRead   = rdOk && hit(slot, IDX_LST);
    strobes.msrRead   = rdOk && hit(slot, IDX_MST);
    strobes.causeRead = rdOk && hit(slot, IDX_ICS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable     <= 1'b0;
      intEnable  <= '0;
      lineCfg    <= '0;
      modemCfg   <= '0;
      queueMode  <= 1'b0;
      rxLevelSel <= '0;
      divisor    <= '0;
    end else if (wrOk) begin
      if (hit(slot, IDX_ENA)) enable    <= busWdata[0];
      if (hit(slot, IDX_IEN)) intEnable <= busWdata[3:0];
      if (hit(slot, IDX_LCT)) lineCfg   <= busWdata[6:0];
      if (hit(slot, IDX_MCT)) modemCfg  <= busWdata[4:0];
      if (hit(slot, IDX_DIV)) divisor   <= busWdata[DIV_W-1:0];
      if (hit(slot, IDX_QCT)) begin
        queueMode  <= busWdata[0];
        rxLevelSel <= busWdata[7:6];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (hit(slot, IDX_RXD))      busRdata[7:0] = status.rxHead;
    else if (hit(slot, IDX_IEN)) busRdata[3:0] = intEnable;
    else if (hit(slot, IDX_ICS)) busRdata[7:0] = status.intCause;
    else if (hit(slot, IDX_LCT)) busRdata[6:0] = lineCfg;
    else if (hit(slot, IDX_MCT)) busRdata[4:0] = modemCfg;
    else if (hit(slot, IDX_LST)) busRdata[7:0] = status.lineStat;
    else if (hit(slot, IDX_MST)) busRdata[7:0] = status.modemStat;
    else if (hit(slot, IDX_DIV)) busRdata[DIV_W-1:0] = divisor;
    else if (hit(slot, IDX_ENA)) busRdata[0] = enable;
  end

  assert_be_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busBe != 4'hF) |=>
      ($stable(lineCfg) && $stable(divisor) && $stable(enable) && $stable(intEnable)));
endmodule

// File: rtl/flat_uart_dp.sv
module flat_uart_dp
  import flat_uart_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  uartStrobes_t     strobes,
  input  logic             enable,
  input  logic [3:0]       intEnable,
  input  logic             queueMode,
  input  logic [1:0]       rxLevelSel,
  input  logic [DIV_W-1:0] divisor,
  output uartStatus_t      status,
  output logic             txValid,
  output logic [7:0]       txByte,
  input  logic             txTake,
  input  logic             rxPush,
  input  logic [7:0]       rxByte,
  input  logic [3:0]       modemIn,
  output logic             baudTick,
  output logic             irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] txCount, rxCount, rxLevel;
  logic txEmpty, txFull, rxEmpty, rxFull;
  logic txPushOk, txTakeOk, rxPushOk, rxPopOk;
  logic overrun, threPending;
  logic [3:0] modemQ, modemDelta;
  logic [DIV_W-1:0] baudCnt;
  logic baudRun;
  logic srcLine, srcRx, srcThre, srcModem;

  assign txPushOk = enable && strobes.txPush;
  assign txTakeOk = enable && txTake && !txEmpty;
  assign rxPushOk = enable && rxPush;
  assign rxPopOk  = enable && strobes.rxPop;

  flat_uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) txQ_i (
    .clk(clk), .rstN(rstN), .push(txPushOk), .pop(txTakeOk), .clear(strobes.txClear),
    .din(strobes.txData), .dout(txByte), .count(txCount), .full(txFull), .empty(txEmpty));

  flat_uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) rxQ_i (
    .clk(clk), .rstN(rstN), .push(rxPushOk), .pop(rxPopOk), .clear(strobes.rxClear),
    .din(rxByte), .dout(status.rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty));

  assign txValid = enable && !txEmpty;

  always_comb begin
    rxLevel = CW'(1);
    if (queueMode) begin
      case (rxLevelSel)
        2'd0: rxLevel = CW'(1);
        2'd1: rxLevel = CW'(DEPTH / 4);
        2'd2: rxLevel = CW'(DEPTH / 2);
        default: rxLevel = CW'(DEPTH - 2);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrun <= 1'b0;
    else if (rxPushOk && rxFull && !rxPopOk) overrun <= 1'b1;
    else if (strobes.lsrRead) overrun <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) threPending <= 1'b0;
    else if ((txTakeOk && txCount == CW'(1) && !txPushOk) ||
             (strobes.txClear && !txEmpty) ||
             (strobes.threArm && txEmpty)) threPending <= 1'b1;
    else if (txPushOk || (strobes.causeRead && status.intCause[3:0] == 4'h2))
      threPending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modemQ     <= '0;
      modemDelta <= '0;
    end else begin
      modemQ     <= modemIn;
      modemDelta <= (modemDelta & ~{4{strobes.msrRead}}) | (modemIn ^ modemQ);
    end
  end

  assign baudRun = enable && (divisor != '0) && !strobes.divWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCnt  <= '0;
      baudTick <= 1'b0;
    end else if (!baudRun) begin
      baudCnt  <= '0;
      baudTick <= 1'b0;
    end else if (baudCnt == divisor - 1'b1) begin
      baudCnt  <= '0;
      baudTick <= 1'b1;
    end else begin
      baudCnt  <= baudCnt + 1'b1;
      baudTick <= 1'b0;
    end
  end

  assign srcLine  = intEnable[2] && overrun;
  assign srcRx    = intEnable[0] && (rxCount >= rxLevel);
  assign srcThre  = intEnable[1] && threPending;
  assign srcModem = intEnable[3] && (modemDelta != '0);

  always_comb begin
    status.intCause = {queueMode, queueMode, 6'b000001};
    if (srcLine)       status.intCause[3:0] = 4'h6;
    else if (srcRx)    status.intCause[3:0] = 4'h4;
    else if (srcThre)  status.intCause[3:0] = 4'h2;
    else if (srcModem) status.intCause[3:0] = 4'h0;
  end

  assign status.lineStat  = {1'b0, txEmpty, txEmpty, 3'b000, overrun, !rxEmpty};
  assign status.modemStat = {modemQ, modemDelta};
  assign irq = srcLine || srcRx || srcThre || srcModem;

  assert_idle_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !baudTick);
  assert_div_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |=> !baudTick);
  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && rxPush && rxFull && !strobes.rxPop) |=> status.lineStat[1]);
endmodule

// File: rtl/flat_uart_regs.sv
module flat_uart_regs
  import flat_uart_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txTake,
  input  logic              rxPush,
  input  logic [7:0]        rxByte,
  input  logic [3:0]        modemIn,
  output logic [4:0]        modemOut,
  output logic [6:0]        lineCfg,
  output logic              baudTick,
  output logic              irq
);
  uartStrobes_t strobes;
  uartStatus_t  status;
  logic enable, queueMode;
  logic [3:0] intEnable;
  logic [1:0] rxLevelSel;
  logic [DIV_W-1:0] divisor;

  flat_uart_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .status(status),
    .strobes(strobes), .enable(enable), .intEnable(intEnable), .lineCfg(lineCfg),
    .modemCfg(modemOut), .queueMode(queueMode), .rxLevelSel(rxLevelSel), .divisor(divisor));

  flat_uart_dp #(.DEPTH(DEPTH), .DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .enable(enable), .intEnable(intEnable),
    .queueMode(queueMode), .rxLevelSel(rxLevelSel), .divisor(divisor), .status(status),
    .txValid(txValid), .txByte(txByte), .txTake(txTake), .rxPush(rxPush), .rxByte(rxByte),
    .modemIn(modemIn), .baudTick(baudTick), .irq(irq));
endmodule

// File: tb/flat_uart_regs_tb.sv
module flat_uart_regs_tb_top;
  localparam logic [8:0] A_RXD = 9'h000, A_TXD = 9'h004, A_IEN = 9'h008, A_ICS = 9'h00C,
                         A_QCT = 9'h010, A_LCT = 9'h014, A_MCT = 9'h018, A_LST = 9'h01C,
                         A_MST = 9'h020, A_GAP = 9'h024, A_DIV = 9'h028, A_ENA = 9'h100;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 0, busWrite = 0;
  logic [8:0] busAddr = '0;
  logic [3:0] busBe = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic txValid, txTake = 0, rxPush = 0, baudTick, irq;
  logic [7:0] txByte, rxByte = '0;
  logic [3:0] modemIn = '0;
  logic [4:0] modemOut;
  logic [6:0] lineCfg;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flat_uart_regs dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .txValid(txValid),
    .txByte(txByte), .txTake(txTake), .rxPush(rxPush), .rxByte(rxByte), .modemIn(modemIn),
    .modemOut(modemOut), .lineCfg(lineCfg), .baudTick(baudTick), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d; busBe = be;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0; busBe = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic rdChk(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic rxIn(input logic [7:0] b);
    @(negedge clk);
    rxPush = 1; rxByte = b;
    @(posedge clk); #1;
    rxPush = 0;
  endtask

  task automatic txOut();
    @(negedge clk);
    txTake = 1;
    @(posedge clk); #1;
    txTake = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 txValid", txValid, 0);
    chk("R1 irq", irq, 0);
    rdChk("R1 cause", A_ICS, 32'h01);
    rdChk("R1 line status", A_LST, 32'h60);
    rdChk("R1 int enable", A_IEN, 0);
    rdChk("R1 divisor", A_DIV, 0);
    rdChk("R1 enable", A_ENA, 0);
  endtask

  task automatic t_disabled();
    wr(A_TXD, 32'hAA);
    @(negedge clk);
    chk("R4 txValid idle", txValid, 0);
    rdChk("R4 line status after tx write", A_LST, 32'h60);
    rxIn(8'h55);
    rdChk("R4 line status after rx push", A_LST, 32'h60);
    wr(A_DIV, 3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R4 tick idle", baudTick, 0);
    end
  endtask

  task automatic t_slots();
    wr(A_LCT, 32'hFFFF_FF03);
    wr(A_MCT, 32'h0000_0011);
    wr(A_IEN, 32'h05);
    wr(A_DIV, 32'hABCD_1234);
    rdChk("R2 line control upper zero", A_LCT, 32'h03);
    rdChk("R2 modem control", A_MCT, 32'h11);
    rdChk("R2 int enable", A_IEN, 32'h05);
    rdChk("R2 divisor", A_DIV, 32'h1234);
    rdChk("R2 unmapped", A_GAP, 0);
    rdChk("R2 queue control reads zero", A_QCT, 0);
    wr(A_IEN, 0);
    wr(A_LCT, 32'h5A, 4'h1);
    rdChk("R3 partial write ignored", A_LCT, 32'h03);
    wr(A_DIV, 32'h7, 4'h3);
    rdChk("R3 partial divisor ignored", A_DIV, 32'h1234);
    wr(A_LCT, 32'hFF);
    wr(A_MCT, 32'hFF);
    rdChk("R7 line control bit7", A_LCT, 32'h7F);
    rdChk("R7 modem control bit5", A_MCT, 32'h1F);
    @(negedge clk);
    chk("R7 modemOut", modemOut, 5'h1F);
    chk("R7 lineCfg", lineCfg, 7'h7F);
  endtask

  task automatic t_txq();
    wr(A_ENA, 1);
    rdChk("R2 enable readback", A_ENA, 1);
    for (int i = 0; i < 17; i++) wr(A_TXD, 32'h10 + i);
    rdChk("R6 line status tx busy", A_LST, 32'h00);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R5 txValid", txValid, 1);
      chk("R5 tx order", txByte, 8'h10 + i);
      txOut();
    end
    @(negedge clk);
    chk("R5 drained after 16", txValid, 0);
  endtask

  task automatic t_rxq();
    rxIn(8'h21); rxIn(8'h22); rxIn(8'h23);
    rdChk("R6 data ready", A_LST, 32'h61);
    rdChk("R6 rx first", A_RXD, 32'h21);
    rdChk("R6 rx second", A_RXD, 32'h22);
    rdChk("R6 rx third", A_RXD, 32'h23);
    rdChk("R6 empty again", A_LST, 32'h60);
    for (int i = 0; i < 17; i++) rxIn(8'h40 + i);
    rdChk("R6 overrun set", A_LST, 32'h63);
    rdChk("R6 overrun cleared by read", A_LST, 32'h61);
    rdChk("R6 oldest kept", A_RXD, 32'h40);
    wr(A_QCT, 32'h02);
    rdChk("R11 rx flush", A_LST, 32'h60);
  endtask

  task automatic t_baud();
    int gap;
    wr(A_DIV, 5);
    gap = 0;
    for (int i = 0; i < 20 && !baudTick; i++) @(negedge clk);
    chk("R8 tick seen", baudTick, 1);
    @(negedge clk);
    gap = 1;
    while (!baudTick && gap < 20) begin
      @(negedge clk);
      gap++;
    end
    chk("R8 period 5", gap, 5);
    wr(A_DIV, 1);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 divisor 1 steady", baudTick, 1);
    end
    wr(A_DIV, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R8 divisor 0 stops", baudTick, 0);
    end
  endtask

  task automatic t_level();
    wr(A_QCT, 32'h41);
    wr(A_IEN, 32'h01);
    rxIn(1); rxIn(2); rxIn(3);
    @(negedge clk);
    chk("R11 below level irq", irq, 0);
    rdChk("R11 below level cause", A_ICS, 32'hC1);
    rxIn(4);
    @(negedge clk);
    chk("R13 at level irq", irq, 1);
    rdChk("R11 at level cause", A_ICS, 32'hC4);
    wr(A_TXD, 32'h99);
    wr(A_QCT, 32'h44);
    rdChk("R11 tx flush", A_LST, 32'h61);
  endtask

  task automatic t_prio();
    wr(A_QCT, 32'h06);
    wr(A_IEN, 32'h0F);
    @(negedge clk);
    chk("R13 thre irq", irq, 1);
    rdChk("R10 thre reported", A_ICS, 32'h02);
    rdChk("R10 thre cleared", A_ICS, 32'h01);
    @(negedge clk);
    chk("R13 irq low", irq, 0);
    @(negedge clk) modemIn = 4'b0001;
    @(negedge clk);
    rdChk("R9 modem cause", A_ICS, 32'h00);
    rdChk("R12 modem status", A_MST, 32'h11);
    rdChk("R12 delta cleared", A_MST, 32'h10);
    rdChk("R9 none after modem read", A_ICS, 32'h01);
    @(negedge clk) modemIn = 4'b0011;
    rxIn(8'hE0);
    rdChk("R9 rx over modem", A_ICS, 32'h04);
    for (int i = 0; i < 16; i++) rxIn(8'hE1 + i);
    rdChk("R9 line over rx", A_ICS, 32'h06);
    rdChk("R6 line status full overrun", A_LST, 32'h63);
    rdChk("R9 rx after overrun clear", A_ICS, 32'h04);
    wr(A_QCT, 32'h02);
    rdChk("R9 modem after rx flush", A_ICS, 32'h00);
    rdChk("R12 second change", A_MST, 32'h32);
    rdChk("R9 idle", A_ICS, 32'h01);
    wr(A_TXD, 32'h77);
    txOut();
    @(negedge clk);
    chk("R10 irq on tx drain", irq, 1);
    rdChk("R10 thre on drain", A_ICS, 32'h02);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_disabled();
    t_slots();
    t_txq();
    t_rxq();
    t_baud();
    t_level();
    t_prio();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule